// File: doc/BRIEF.md
# Audio Master-Clock and Bit-Clock Prescaler

This block turns a fast audio kernel clock into the three timing signals of a stereo serial audio link: an optional master clock for an external converter, the bit clock, and the word-select (frame) clock. A programmable linear divider DIV, together with an odd-step flag, sets a prescale ratio of 2×DIV+ODD kernel cycles. With the master clock enabled, the prescaler output is the master clock and the bit clock is that clock further divided by 8 (16-bit slots) or 4 (32-bit slots), which fixes the master clock at 256 times the sample rate. With it disabled, the prescaler output drives the bit clock directly and the master-clock pin stays low.

Word select toggles once per channel slot, so one full period spans a stereo frame. A new configuration is sampled only at a frame boundary, so the outputs never show a shortened pulse when software reprograms the divider. All outputs are registered in the kernel clock domain.

Top module: `audio_clk_prescaler`

## Requirements
- R1: `cfgWord` holds DIV in bits 7:0, ODD in bit 8 and the master-clock enable in bit 9; `frameLong` = 0 selects 16-bit channel slots, 1 selects 32-bit slots.
- R2: With the enable set, `mclkOut` has a period of exactly 2×DIV+ODD kernel cycles.
- R3: A DIV field of 0 or 1 behaves exactly like DIV = 2.
- R4: Within each prescaler period the high phase lasts DIV kernel cycles and the low phase DIV+ODD cycles, so an odd ratio gives a high phase one cycle shorter than the low phase.
- R5: While the enable bit is 0, `mclkOut` stays low.
- R6: With the enable set, `bclkOut` has a period of 8×(2×DIV+ODD) kernel cycles for 16-bit slots and 4×(2×DIV+ODD) for 32-bit slots, each with a 50 % duty cycle.
- R7: With the enable clear, `bclkOut` has a period of 2×DIV+ODD kernel cycles with a high phase of DIV cycles.
- R8: `wsOut` is low for the first slot of each frame and high for the second, each slot lasting 16 or 32 bit-clock periods as selected.
- R9: Every transition of `wsOut` happens in the same kernel cycle as a falling edge of `bclkOut`.
- R10: A configuration change takes effect only at the next frame boundary (the falling edge of `wsOut`); the frame in progress finishes with the old settings.
- R11: During reset all three outputs are low, and after reset a frame starts with `wsOut` low using the configuration present as reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Audio kernel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWord | input | 10 | Divider, odd flag and master-clock enable |
| frameLong | input | 1 | Slot length select: 0 = 16 bits, 1 = 32 bits |
| mclkOut | output | 1 | Master clock, low when disabled |
| bclkOut | output | 1 | Bit clock |
| wsOut | output | 1 | Word select, low for the first channel |

## Verification
The hardest condition to reach from the ports is a configuration change that lands mid-frame, because the effect of a premature load shows up only as a bit-clock period that differs from the expected one before the next word-select fall. The stimulus rewrites the configuration at the rising edge of word select, halfway through a frame whose bit-clock period differs sharply from the new one, and checks every bit-clock period until the frame closes, then measures the next frame against the new settings. Random configurations from a seeded generator cover both slot lengths, both enable states and odd and even ratios, while directed cases cover the clamped divider values and the largest ratio.

// File: rtl/acp_pkg.sv
package acp_pkg;
  localparam int DIV_W        = 8;
  localparam int RATIO_W      = DIV_W + 1;
  localparam int CFG_W        = DIV_W + 2;
  localparam int SHORT_BITS   = 16;
  localparam int LONG_BITS    = 32;
  localparam int SHORT_MCKDIV = 8;
  localparam int LONG_MCKDIV  = 4;
  localparam int SUB_W        = $clog2(SHORT_MCKDIV);
  localparam int BIT_W        = $clog2(2 * LONG_BITS);

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             odd;
    logic             mclkEn;
    logic             longFrame;
  } cfg_t;

  typedef struct packed {
    logic [RATIO_W-1:0] ratio;
    logic [RATIO_W-1:0] lowLen;
    logic [SUB_W-1:0]   subLast;
    logic [SUB_W-1:0]   subHalf;
    logic [BIT_W-1:0]   bitLast;
    logic [BIT_W-1:0]   bitHalf;
    logic               mclkEn;
  } limits_t;

  typedef struct packed {
    logic load;
  } strobes_t;
endpackage

// File: rtl/acp_ctrl.sv
module acp_ctrl
  import acp_pkg::*;
#(
  parameter int MIN_DIV = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             frameLong,
  input  logic             frameEnd,
  output limits_t          lim,
  output strobes_t         strb
);
  localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(MIN_DIV);

  cfg_t active;
  cfg_t incoming;
  logic primed;

  // R1: field positions of the configuration word
  always_comb begin
    incoming.div       = (cfgWord[DIV_W-1:0] < DIV_FLOOR) ? DIV_FLOOR : cfgWord[DIV_W-1:0];
    incoming.odd       = cfgWord[DIV_W];
    incoming.mclkEn    = cfgWord[DIV_W+1];
    incoming.longFrame = frameLong;
  end

  assign strb.load = primed | frameEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active.div       <= DIV_FLOOR;
      active.odd       <= 1'b0;
      active.mclkEn    <= 1'b0;
      active.longFrame <= 1'b0;
      primed           <= 1'b1;
    end else begin
      primed <= 1'b0;
      if (strb.load) active <= incoming;
    end
  end

  always_comb begin
    lim.ratio  = {active.div, active.odd};
    lim.lowLen = RATIO_W'(active.div) + RATIO_W'(active.odd);
    lim.mclkEn = active.mclkEn;
    if (active.mclkEn) begin
      lim.subLast = active.longFrame ? SUB_W'(LONG_MCKDIV - 1) : SUB_W'(SHORT_MCKDIV - 1);
      lim.subHalf = active.longFrame ? SUB_W'(LONG_MCKDIV / 2) : SUB_W'(SHORT_MCKDIV / 2);
    end else begin
      lim.subLast = '0;
      lim.subHalf = '0;
    end
    lim.bitLast = active.longFrame ? BIT_W'(2 * LONG_BITS - 1) : BIT_W'(2 * SHORT_BITS - 1);
    lim.bitHalf = active.longFrame ? BIT_W'(LONG_BITS) : BIT_W'(SHORT_BITS);
  end

  assert_div_floor_R3: assert property (@(posedge clk) disable iff (!rstN)
    lim.ratio >= RATIO_W'(2 * MIN_DIV));
endmodule

// File: rtl/acp_datapath.sv
module acp_datapath
  import acp_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  limits_t  lim,
  input  strobes_t strb,
  output logic     frameEnd,
  output logic     mclkOut,
  output logic     bclkOut,
  output logic     wsOut
);
  logic [RATIO_W-1:0] phaseCnt;
  logic [SUB_W-1:0]   subCnt;
  logic [BIT_W-1:0]   bitCnt;
  logic preWrap, bitWrap, preLevel;

  assign preWrap  = (phaseCnt == lim.ratio - RATIO_W'(1));
  assign bitWrap  = preWrap && (subCnt == lim.subLast);
  assign frameEnd = bitWrap && (bitCnt == lim.bitLast);
  assign preLevel = (phaseCnt >= lim.lowLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      subCnt   <= '0;
      bitCnt   <= '0;
    end else if (strb.load) begin
      phaseCnt <= '0;
      subCnt   <= '0;
      bitCnt   <= '0;
    end else begin
      phaseCnt <= preWrap ? '0 : phaseCnt + RATIO_W'(1);
      if (preWrap) subCnt <= (subCnt == lim.subLast) ? '0 : subCnt + SUB_W'(1);
      if (bitWrap) bitCnt <= bitCnt + BIT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mclkOut <= 1'b0;
      bclkOut <= 1'b0;
      wsOut   <= 1'b0;
    end else begin
      mclkOut <= lim.mclkEn & preLevel;
      bclkOut <= lim.mclkEn ? (subCnt >= lim.subHalf) : preLevel;
      wsOut   <= (bitCnt >= lim.bitHalf);
    end
  end

  assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    phaseCnt < lim.ratio);

  assert_mclk_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(lim.mclkEn) |-> !mclkOut);

  assert_ws_on_fall_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(wsOut) || $fell(wsOut)) |-> $fell(bclkOut));

  assert_frame_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN, 2) && !$past(frameEnd)) |-> $stable(lim));
endmodule

// File: rtl/audio_clk_prescaler.sv
module audio_clk_prescaler
  import acp_pkg::*;
#(
  parameter int MIN_DIV = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             frameLong,
  output logic             mclkOut,
  output logic             bclkOut,
  output logic             wsOut
);
  limits_t  lim;
  strobes_t strb;
  logic     frameEnd;

  acp_ctrl #(.MIN_DIV(MIN_DIV)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .frameLong(frameLong),
    .frameEnd(frameEnd), .lim(lim), .strb(strb)
  );

  acp_datapath i_datapath (
    .clk(clk), .rstN(rstN), .lim(lim), .strb(strb), .frameEnd(frameEnd),
    .mclkOut(mclkOut), .bclkOut(bclkOut), .wsOut(wsOut)
  );
endmodule

// File: tb/test_audio_clk_prescaler.sv
module test_audio_clk_prescaler;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] cfgWord = '0;
  logic       frameLong = 1'b0;
  logic       mclkOut, bclkOut, wsOut;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  audio_clk_prescaler i_audio_clk_prescaler (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .frameLong(frameLong),
    .mclkOut(mclkOut), .bclkOut(bclkOut), .wsOut(wsOut)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  // R1: DIV in bits 7:0, ODD in bit 8, enable in bit 9
  function automatic logic [9:0] packCfg(input int d, input bit o, input bit e);
    return {e, o, 8'(d)};
  endfunction

  function automatic int effDiv(input int d);
    return (d < 2) ? 2 : d;
  endfunction

  task automatic waitWsFall();
    bit prevW = wsOut;
    for (int t = 0; t < 60000; t++) begin
      @(negedge clk);
      if (prevW && !wsOut) return;
      prevW = wsOut;
    end
    check(1'b0, "R8 word select never fell", 0, 1);
  endtask

  // Measures one frame starting just after a word-select fall.
  task automatic measureFrame(input int d, input bit o, input bit e, input bit lng,
                              input bit applyB, input int dB, input bit oB, input bit eB,
                              input bit lngB, input string tag);
    int r = 2 * effDiv(d) + o;
    int hi = effDiv(d);
    int mdiv = e ? (lng ? 4 : 8) : 1;
    int bits = lng ? 32 : 16;
    int pb = r * mdiv;
    int hb = e ? pb / 2 : hi;
    int lastMR = -1, lastBR = -1, bRises = 0;
    int eMp = 0, aMp = 0, eMh = 0, aMh = 0, eMq = 0;
    int eBp = 0, aBp = 0, eBh = 0, aBh = 0;
    int eWl = 0, aWl = 0, eWa = 0, wsRose = 0;
    bit prevM = mclkOut, prevB = bclkOut, prevW = wsOut, done = 0;
    for (int t = 1; t < 150000 && !done; t++) begin
      @(negedge clk);
      if (!e && mclkOut) eMq++;
      if (e && mclkOut && !prevM) begin
        if (lastMR >= 0 && t - lastMR != r) begin eMp++; aMp = t - lastMR; end
        lastMR = t;
      end
      if (e && !mclkOut && prevM && lastMR >= 0 && t - lastMR != hi) begin
        eMh++; aMh = t - lastMR;
      end
      if (bclkOut && !prevB) begin
        if (lastBR >= 0 && t - lastBR != pb) begin eBp++; aBp = t - lastBR; end
        lastBR = t;
        bRises++;
      end
      if (!bclkOut && prevB && lastBR >= 0 && t - lastBR != hb) begin
        eBh++; aBh = t - lastBR;
      end
      if (wsOut != prevW) begin
        if (!(prevB && !bclkOut)) eWa++;
        if (bRises != bits) begin eWl++; aWl = bRises; end
        bRises = 0;
        if (wsOut) begin
          wsRose++;
          if (applyB) begin
            cfgWord = packCfg(dB, oB, eB);
            frameLong = lngB;
          end
        end else done = 1;
      end
      prevM = mclkOut; prevB = bclkOut; prevW = wsOut;
    end
    check(done && wsRose == 1, {"R8 frame with one low and one high slot ", tag}, wsRose, 1);
    if (e) begin
      check(eMp == 0, {"R2 R1 master clock period ", tag}, aMp, r);
      check(eMh == 0, {"R4 master clock high phase ", tag}, aMh, hi);
      check(eBp == 0, {"R6 bit clock period ", tag}, aBp, pb);
      check(eBh == 0, {"R6 bit clock duty ", tag}, aBh, hb);
    end else begin
      check(eMq == 0, {"R5 master clock held low ", tag}, eMq, 0);
      check(eBp == 0, {"R7 bit clock period ", tag}, aBp, pb);
      check(eBh == 0, {"R7 R4 bit clock high phase ", tag}, aBh, hb);
    end
    check(eWl == 0, {"R8 slot length in bit clocks ", tag}, aWl, bits);
    check(eWa == 0, {"R9 word select on bit clock fall ", tag}, eWa, 0);
  endtask

  task automatic runCfg(input int d, input bit o, input bit e, input bit lng, input string tag);
    cfgWord = packCfg(d, o, e);
    frameLong = lng;
    waitWsFall();
    measureFrame(d, o, e, lng, 1'b0, 0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd2417);
    cfgWord = packCfg(3, 1'b1, 1'b0);
    frameLong = 1'b0;
    repeat (3) @(negedge clk);
    // R11: all outputs low in reset
    check(!mclkOut && !bclkOut && !wsOut, "R11 outputs low during reset",
          {mclkOut, bclkOut, wsOut}, 0);
    rstN = 1'b1;
    // R11: first frame uses the configuration present at reset release
    measureFrame(3, 1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R11 first frame");

    runCfg(0, 1'b1, 1'b1, 1'b0, "R3 div0 odd");
    runCfg(1, 1'b0, 1'b0, 1'b1, "R3 div1 even");
    runCfg(12, 1'b1, 1'b0, 1'b0, "odd ratio 25");
    runCfg(255, 1'b1, 1'b0, 1'b0, "largest ratio");

    // R10: change mid-frame, old settings must hold until frame end
    runCfg(3, 1'b0, 1'b1, 1'b0, "before change");
    measureFrame(3, 1'b0, 1'b1, 1'b0, 1'b1, 2, 1'b1, 1'b0, 1'b1, "R10 change held off");
    measureFrame(2, 1'b1, 1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R10 new settings");

    for (int i = 0; i < 8; i++) begin
      int d = 2 + int'($urandom_range(5, 0));
      bit o = 1'($urandom_range(1, 0));
      bit e = 1'($urandom_range(1, 0));
      bit l = 1'($urandom_range(1, 0));
      runCfg(d, o, e, l, $sformatf("random div %0d odd %0d en %0d long %0d", d, o, e, l));
    end

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule